// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches all 32 input pins of one general-purpose I/O port and turns pin activity into interrupt requests. Every pin carries a two-bit trigger code that selects one of four conditions: rising edge, falling edge, high level or low level. A pin takes part in detection only when it is configured for GPIO use and set as an input. Pin inputs pass through a two-flop synchronizer. An edge is found by comparing the synchronized value with its value one cycle earlier.

A detected condition sets the pin's bit in a sticky status register. Software clears status bits by writing ones to them. A mask register picks which status bits drive the single port interrupt line, so one output stands for all 32 pins. A downstream demultiplexer reads the status word to find which pins fired. Status bits latch whether or not the pin is masked. Level conditions set their bit again on every cycle while the level holds.

Registers sit on a plain 32-bit write bus with a word address. Reads are combinational from the word address.

Top module: `gpio_irq_port`

## Requirements
- R1: Trigger code 0 sets a pin's status on a 0-to-1 change of its synchronized input. Code 1 sets it on a 1-to-0 change.
- R2: Code 2 (high level) and code 3 (low level) set the status bit on every cycle the level is present. A write-one clear therefore only holds once the level has gone away.
- R3: Pins 0 to 15 take their code from config word A at word address 2, and pins 16 to 31 from config word B at word address 3. Pin p uses bits [2*(p mod 16)+1 : 2*(p mod 16)] of its word.
- R4: Writing the status register at word address 5 clears each bit written as 1. Bits written as 0 keep their value.
- R5: The mask register at word address 4 lets a status bit drive `irq_out` only where the mask bit is 1. The mask resets to 0, so every pin starts masked.
- R6: A pin detects only when its bit in the use register (word 0) is 1 and its bit in the direction register (word 1) is 0. Other pins never set status.
- R7: `irq_out` is high exactly when some status bit is set together with its mask bit.
- R8: A pin change takes effect through two synchronizer flops. A change that the clock edge k first samples sets status at edge k+2.
- R9: When a detected event and a clear write hit the same status bit at the same edge, the bit stays set.
- R10: Status bits latch whatever the mask is. Setting the mask bit of a pending pin raises `irq_out` straight after the mask write.
- R11: Synchronous active-high reset clears every register. Word addresses 6 and 7 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pins_in | input | 32 | Asynchronous port pin levels |
| irq_out | output | 1 | Combined port interrupt |

## Verification
A new event on a pin and a write-one clear of the same status bit can land on the same edge. The bench provokes this for an edge-triggered pin by timing the clear write to the edge that follows the second synchronizer stage. It does the same for a level-held pin by clearing while the level persists. In both cases the bit must read back as 1. The randomized phase issues all-ones and random clears while pins toggle, which hits the same overlap many more times. A cycle-level bench model then judges every status read and every `irq_out` sample.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int PORT_W       = 32;
    localparam int CODE_W       = 2;
    localparam int PINS_PER_CFG = PORT_W / CODE_W;
    localparam int REG_AW       = 3;
    localparam int SYNC_DEPTH   = 2;

    typedef enum logic [CODE_W-1:0] {
        TRIG_RISE = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_HIGH = 2'd2,
        TRIG_LOW  = 2'd3
    } trig_e;

    typedef enum logic [REG_AW-1:0] {
        RSEL_USE    = 3'd0,
        RSEL_DIR    = 3'd1,
        RSEL_CFG_A  = 3'd2,
        RSEL_CFG_B  = 3'd3,
        RSEL_MASK   = 3'd4,
        RSEL_STATUS = 3'd5
    } rsel_e;

    typedef struct packed {
        logic [PORT_W-1:0] use_en;
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] cfg_a;
        logic [PORT_W-1:0] cfg_b;
        logic [PORT_W-1:0] mask;
    } port_cfg_t;

    // Condition match for one pin given its trigger and sampled history.
    function automatic logic trig_hit(input trig_e code, input logic cur, input logic prev);
        logic hit;
        case (code)
            TRIG_RISE: hit = cur & ~prev;
            TRIG_FALL: hit = ~cur & prev;
            TRIG_HIGH: hit = cur;
            TRIG_LOW:  hit = ~cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output port_cfg_t         cfg_q,
    output logic [PORT_W-1:0] clr_vec
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                RSEL_USE:   cfg_q.use_en <= bus_wdata;
                RSEL_DIR:   cfg_q.dir    <= bus_wdata;
                RSEL_CFG_A: cfg_q.cfg_a  <= bus_wdata;
                RSEL_CFG_B: cfg_q.cfg_b  <= bus_wdata;
                RSEL_MASK:  cfg_q.mask   <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_vec = '0;
        if (bus_wr && bus_addr == RSEL_STATUS) begin
            clr_vec = bus_wdata;
        end
    end
endmodule

// File: rtl/gpio_irq_pin_detect.sv
module gpio_irq_pin_detect
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] cur,
    input  logic [PORT_W-1:0] use_en,
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] cfg_a,
    input  logic [PORT_W-1:0] cfg_b,
    output logic [PORT_W-1:0] pin_ev
);
    logic [PORT_W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= cur;
    end

    for (genvar p = 0; p < PORT_W; p++) begin : g_pin
        localparam int SLOT = (p % PINS_PER_CFG) * CODE_W;
        trig_e code;
        if (p < PINS_PER_CFG) begin : g_word_a
            assign code = trig_e'(cfg_a[SLOT +: CODE_W]);
        end else begin : g_word_b
            assign code = trig_e'(cfg_b[SLOT +: CODE_W]);
        end
        assign pin_ev[p] = use_en[p] & ~dir[p] & trig_hit(code, cur[p], prev[p]);
    end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] pin_ev,
    input  logic [PORT_W-1:0] clr_vec,
    output logic [PORT_W-1:0] status_q
);
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_vec) | pin_ev;
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pins_in,
    output logic              irq_out
);
    port_cfg_t         cfg_q;
    logic [PORT_W-1:0] clr_vec;
    logic [PORT_W-1:0] pins_sync;
    logic [PORT_W-1:0] pin_ev;
    logic [PORT_W-1:0] status_q;

    gpio_irq_sync #(.W(PORT_W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .d(pins_in), .q(pins_sync)
    );

    gpio_irq_regs u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cfg_q(cfg_q), .clr_vec(clr_vec)
    );

    gpio_irq_pin_detect u_detect (
        .clk(clk), .rst(rst), .cur(pins_sync),
        .use_en(cfg_q.use_en), .dir(cfg_q.dir),
        .cfg_a(cfg_q.cfg_a), .cfg_b(cfg_q.cfg_b), .pin_ev(pin_ev)
    );

    gpio_irq_status u_status (
        .clk(clk), .rst(rst), .pin_ev(pin_ev), .clr_vec(clr_vec), .status_q(status_q)
    );

    always_comb begin
        case (bus_addr)
            RSEL_USE:    bus_rdata = cfg_q.use_en;
            RSEL_DIR:    bus_rdata = cfg_q.dir;
            RSEL_CFG_A:  bus_rdata = cfg_q.cfg_a;
            RSEL_CFG_B:  bus_rdata = cfg_q.cfg_b;
            RSEL_MASK:   bus_rdata = cfg_q.mask;
            RSEL_STATUS: bus_rdata = status_q;
            default:     bus_rdata = '0;
        endcase
    end

    assign irq_out = |(status_q & cfg_q.mask);
endmodule

// File: rtl/gpio_irq_port_checker.sv
module gpio_irq_port_checker
    import gpio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [PORT_W-1:0] bus_wdata,
    input logic              irq_out,
    input logic [PORT_W-1:0] status_q,
    input logic [PORT_W-1:0] pin_ev,
    input logic [PORT_W-1:0] clr_vec,
    input port_cfg_t         cfg_q
);
    logic [PORT_W-1:0] qual;
    logic              stat_wr;
    assign qual    = cfg_q.use_en & ~cfg_q.dir;
    assign stat_wr = bus_wr && (bus_addr == RSEL_STATUS);

    // R11: registers are cleared once reset drops
    assert_reset_clear_R11: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (status_q == '0 && cfg_q.mask == '0 && !irq_out));

    // R5: an all-zero mask keeps the interrupt low
    assert_mask_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.mask == '0) |-> !irq_out);

    // R4: only bits written as one may be cleared
    assert_w1c_only_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(status_q) & ~status_q & ~($past(stat_wr) ? $past(bus_wdata) : '0)) == '0));

    // R6: unqualified pins never become set
    assert_unqualified_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(qual)) == '0));

    // R9: a detected event survives a simultaneous clear
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_vec != '0) |=> (($past(pin_ev) & ~status_q) == '0));

    // R7: a set, masked-in status bit raises the interrupt
    assert_irq_any_R7: assert property (@(posedge clk) disable iff (rst)
        (!$stable(status_q) && ((status_q & cfg_q.mask) != '0)) |-> irq_out);
endmodule

bind gpio_irq_port gpio_irq_port_checker u_chk (.*);

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pins_in = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    gpio_irq_port u_gpio_irq_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins_in), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model, advanced on every rising edge.
    logic [31:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_stat = '0;
    logic [31:0] m_use = '0, m_dir = '0, m_a = '0, m_b = '0, m_mask = '0;

    function automatic logic [1:0] b_code(int p, logic [31:0] a, logic [31:0] b);
        logic [31:0] w;
        w = (p < 16) ? (a >> (2 * p)) : (b >> (2 * (p - 16)));
        return w[1:0];
    endfunction

    function automatic logic [31:0] b_events(logic [31:0] cur, logic [31:0] prv);
        logic [31:0] e;
        for (int p = 0; p < 32; p++) begin
            logic hit;
            case (b_code(p, m_a, m_b))
                2'd0: hit = cur[p] && !prv[p];
                2'd1: hit = !cur[p] && prv[p];
                2'd2: hit = cur[p];
                default: hit = !cur[p];
            endcase
            e[p] = hit && m_use[p] && !m_dir[p];
        end
        return e;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_stat <= '0;
            m_use <= '0; m_dir <= '0; m_a <= '0; m_b <= '0; m_mask <= '0;
        end else begin
            logic [31:0] clr;
            clr = (bus_wr && bus_addr == 3'd5) ? bus_wdata : '0;
            m_stat <= (m_stat & ~clr) | b_events(m_s2, m_prev);
            m_prev <= m_s2;
            m_s2   <= m_s1;
            m_s1   <= pins_in;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_use  <= bus_wdata;
                    3'd1: m_dir  <= bus_wdata;
                    3'd2: m_a    <= bus_wdata;
                    3'd3: m_b    <= bus_wdata;
                    3'd4: m_mask <= bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_1234));
        idle(3);
        @(negedge clk) rst = 1'b0;

        // R11: reset state and the unused words
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], d);
            check("R11 reset read", d, 32'h0);
        end
        check("R5 reset irq", {31'h0, irq_out}, 32'h0);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, d); check("R11 unused word", d, 32'h0);

        // R3 + R1: pin 17 falling edge via word B bits [3:2] = 01
        wr(3'd3, 32'h0000_0004);
        wr(3'd0, 32'h0002_0000);
        wr(3'd4, 32'h0002_0000);
        @(negedge clk) pins_in[17] = 1'b1;
        idle(4);
        rd(3'd5, d); check("R1 rising ignored in fall mode", d, 32'h0);
        @(negedge clk) pins_in[17] = 1'b0;
        // R8: sampled at edge k, status updates at edge k+2
        @(negedge clk); #1 check("R8 not yet k", bus_rdata & 32'h0002_0000, 32'h0);
        @(negedge clk); #1 check("R8 not yet k+1", {31'h0, irq_out}, 32'h0);
        @(negedge clk); #1 check("R8 set at k+2 / R7 irq", {31'h0, irq_out}, 32'h1);
        rd(3'd5, d); check("R1 falling latched R3 slot", d, 32'h0002_0000);
        wr(3'd5, 32'h0000_0000);
        rd(3'd5, d); check("R4 write zero keeps", d, 32'h0002_0000);
        wr(3'd5, 32'h0002_0000);
        rd(3'd5, d); check("R4 write one clears", d, 32'h0);
        check("R7 irq drops", {31'h0, irq_out}, 32'h0);

        // R6: pin 3 rising, GPIO use set but configured as output
        wr(3'd0, 32'h0000_0008);
        wr(3'd1, 32'h0000_0008);
        @(negedge clk) pins_in[3] = 1'b1;
        idle(4);
        rd(3'd5, d); check("R6 output pin no event", d, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h0);
        @(negedge clk) pins_in[3] = 1'b0;
        idle(4);
        @(negedge clk) pins_in[3] = 1'b1;
        idle(4);
        rd(3'd5, d); check("R6 unused pin no event", d, 32'h0);

        // R10: pin 5 rising while masked, then unmask
        wr(3'd0, 32'h0000_0020);
        wr(3'd4, 32'h0);
        @(negedge clk) pins_in[5] = 1'b1;
        idle(4);
        rd(3'd5, d); check("R10 latched while masked", d, 32'h0000_0020);
        check("R5 masked no irq", {31'h0, irq_out}, 32'h0);
        wr(3'd4, 32'h0000_0020);
        #1 check("R10 unmask raises irq", {31'h0, irq_out}, 32'h1);
        wr(3'd5, 32'hFFFF_FFFF);

        // R2: pin 8 high level (word A bits [17:16] = 10)
        wr(3'd2, 32'h0002_0000);
        wr(3'd0, 32'h0000_0100);
        @(negedge clk) pins_in[8] = 1'b1;
        idle(4);
        wr(3'd5, 32'h0000_0100);
        rd(3'd5, d); check("R2 level re-sets after clear", d, 32'h0000_0100);
        @(negedge clk) pins_in[8] = 1'b0;
        idle(4);
        wr(3'd5, 32'h0000_0100);
        rd(3'd5, d); check("R2 clear sticks after level gone", d, 32'h0);

        // R9: pin 9 rising edge collides with a clear of the same bit
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h0000_0200);
        @(negedge clk) pins_in[9] = 1'b1;
        idle(4);
        @(negedge clk) pins_in[9] = 1'b0;
        idle(4);
        rd(3'd5, d); check("R9 precondition set", d, 32'h0000_0200);
        @(negedge clk) pins_in[9] = 1'b1;
        idle(2);
        bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h0000_0200;
        @(negedge clk) bus_wr = 1'b0;
        rd(3'd5, d); check("R9 event beats clear", d, 32'h0000_0200);
        wr(3'd5, 32'h0000_0200);
        rd(3'd5, d); check("R4 clear without event", d, 32'h0);

        // Constrained random phase against the model (R1 R2 R3 R5 R7 R10)
        for (int c = 0; c < RAND_CYCLES; c++) begin
            int op;
            @(negedge clk);
            #1 check("R7 irq vs model", {31'h0, irq_out}, {31'h0, |(m_stat & m_mask)});
            if ($urandom_range(0, 3) == 0) pins_in = pins_in ^ (32'h1 << $urandom_range(0, 31));
            op = $urandom_range(0, 15);
            if (op < 5) begin
                bus_wr = 1'b1;
                bus_addr = $urandom_range(0, 5);
                bus_wdata = (bus_addr == 3'd1) ? ($urandom() & $urandom()) : $urandom();
                if (op == 0) begin bus_addr = 3'd5; bus_wdata = 32'hFFFF_FFFF; end
            end else begin
                bus_wr = 1'b0;
                bus_addr = 3'd5;
                #1 check("R1/R2/R3 status vs model", bus_rdata, m_stat);
            end
        end
        @(negedge clk) bus_wr = 1'b0;
        finish_run();
    end
endmodule